// File: doc/BRIEF.md
# Sprite Page Copy Engine with Sample-Fetch Interleave

This block copies one 256-byte page of CPU memory into the sprite memory through a single data-port address. The CPU starts a copy by writing a trigger register, and the byte it writes selects the source page. From the next cycle the engine holds the CPU off and drives the bus itself. For each byte it reads the source location and then writes the value to the data port.

A sample channel may ask for a single byte at any time. The sprite copy is never held back by such a request, and the request is never deferred past the next read slot. The sample read takes the place of a sprite read. The slot after it, which would have been a data-port write, becomes a throwaway read of the CPU's saved program-counter address. The copy then continues with the byte it had not yet read. The CPU supplies its cycle parity. A trigger on an odd cycle adds one alignment cycle. When the engine is idle, a sample request is served by a single stolen read cycle.

Top module: `sprite_dma`

## Requirements
- R1: After reset the engine is idle: `cpuHalt`, `busRe`, `busWe` and `sampleAck` are all low.
- R2: When `trigWe` is high in an idle cycle, `cpuHalt` is high from the next cycle. The first sprite read uses the address `{trigData, 8'h00}`.
- R3: With no sample fetch, `cpuHalt` stays high for exactly 513 consecutive cycles when `cpuOddCycle` was 0 at the trigger, and for 514 when it was 1. It falls in the cycle after the last data-port write.
- R4: The transfer alternates one sprite read of `{page, i}` with one write of that read value to the data-port address (parameter `PORT_ADDR`, default 16'h0F04), for i = 0 to 255 in increasing order.
- R5: A sample request that is high in a read slot turns that slot into a read of `sampleAddr`. The next cycle is a read of `cpuPc`. The following read slot reads the same sprite byte that was displaced. Each such fetch lengthens the transfer by exactly 2 cycles.
- R6: `sampleAck` is high for one cycle, in the cycle after the sample read, with `sampleData` equal to the value read. Sprite data written to the port is unaffected by the fetch.
- R7: A sample request while the engine is idle causes one cycle with `cpuHalt` high and a read of `sampleAddr`. `sampleAck` and `sampleData` follow in the next cycle, with `cpuHalt` low again.
- R8: `trigWe` during a transfer is ignored: the page, the byte order and the length are unchanged.
- R9: When a trigger and a sample request arrive in the same idle cycle, the trigger wins. The sample is fetched in the first read slot of the transfer.
- R10: The bus is never read and written in the same cycle. The bus is idle in the first halted cycle and in the alignment cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-cycle clock |
| rstN | input | 1 | Asynchronous active-low reset |
| trigWe | input | 1 | CPU write strobe to the trigger register |
| trigData | input | 8 | Source page number written with the trigger |
| cpuOddCycle | input | 1 | High when the current CPU cycle is odd |
| cpuPc | input | 16 | CPU's saved program-counter address, used for the throwaway read |
| sampleReq | input | 1 | Sample channel byte request, held until acknowledged |
| sampleAddr | input | 16 | Address of the sample byte |
| sampleAck | output | 1 | One-cycle acknowledge for a completed sample fetch |
| sampleData | output | 8 | Fetched sample byte, valid with `sampleAck` |
| busAddr | output | 16 | Bus address driven by the engine |
| busRe | output | 1 | Bus read strobe |
| busWe | output | 1 | Bus write strobe |
| busWdata | output | 8 | Bus write data |
| busRdata | input | 8 | Bus read data, combinational for the addressed location |
| cpuHalt | output | 1 | Holds the CPU off while the engine owns the bus |

## Verification
The sprite copy and a sample fetch compete for the same read slot. The bench provokes this by raising the sample request in chosen cycles of a transfer: during the first halted cycle, during the alignment cycle, on a read slot, on a write slot just before the last byte, and together with the trigger itself. Each case is judged at the bus. The port must receive all 256 bytes of the page in order with the right values. The throwaway program-counter read and the acknowledge must land in the cycle right after the sample read. The halted span must be exactly two cycles longer than a plain copy of the same parity.

// File: rtl/sprite_dma_pkg.sv
package sprite_dma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HALT,
    ST_ALIGN,
    ST_READ,
    ST_DUMMY,
    ST_WRITE,
    ST_SOLO
  } dmaState_t;

  // strobes from control to datapath, at most one bus strobe per cycle
  typedef struct packed {
    logic loadPage;
    logic rdSprite;
    logic rdSample;
    logic rdPc;
    logic wrPort;
    logic incIdx;
  } dmaStrobe_t;

endpackage

// File: rtl/sprite_dma_ctrl.sv
module sprite_dma_ctrl
  import sprite_dma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       trigWe,
  input  logic       cpuOddCycle,
  input  logic       sampleReq,
  input  logic       sampleAck,
  input  logic       lastIdx,
  output dmaStrobe_t strobe,
  output logic       cpuHalt
);

  dmaState_t state, stateD;
  logic      alignQ;
  logic      takeSample;

  // a request is masked in its acknowledge cycle so it is not served twice
  assign takeSample = sampleReq && !sampleAck;

  always_comb begin
    stateD = state;
    strobe = '0;
    case (state)
      ST_IDLE: begin
        if (trigWe) begin
          strobe.loadPage = 1'b1;
          stateD          = ST_HALT;
        end else if (takeSample) begin
          stateD = ST_SOLO;
        end
      end
      ST_HALT:  stateD = alignQ ? ST_ALIGN : ST_READ;
      ST_ALIGN: stateD = ST_READ;
      ST_READ: begin
        if (takeSample) begin
          strobe.rdSample = 1'b1;
          stateD          = ST_DUMMY;
        end else begin
          strobe.rdSprite = 1'b1;
          stateD          = ST_WRITE;
        end
      end
      ST_DUMMY: begin
        strobe.rdPc = 1'b1;
        stateD      = ST_READ;
      end
      ST_WRITE: begin
        strobe.wrPort = 1'b1;
        strobe.incIdx = 1'b1;
        stateD        = lastIdx ? ST_IDLE : ST_READ;
      end
      ST_SOLO: begin
        strobe.rdSample = 1'b1;
        stateD          = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      alignQ <= 1'b0;
    end else begin
      state <= stateD;
      if (state == ST_IDLE && trigWe) alignQ <= cpuOddCycle;
    end
  end

  assign cpuHalt = (state != ST_IDLE);

  // R2: the CPU is held off in the cycle after an accepted trigger
  a_r2_halt_follows_trigger: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && trigWe) |=> cpuHalt);

  // R3: the halt only drops after a port write or an idle sample read
  a_r3_halt_ends_on_access: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cpuHalt) |-> $past(strobe.wrPort || strobe.rdSample));

  // R5: a sample read inside a transfer is followed by the program-counter read
  a_r5_dummy_after_fetch: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_READ && strobe.rdSample) |=> strobe.rdPc);

endmodule

// File: rtl/sprite_dma_datapath.sv
module sprite_dma_datapath
  import sprite_dma_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter int          IDX_W     = 8,
  parameter logic [15:0] PORT_ADDR = 16'h0F04,
  localparam int         PAGE_W    = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dmaStrobe_t        strobe,
  input  logic [PAGE_W-1:0] trigData,
  input  logic [ADDR_W-1:0] cpuPc,
  input  logic [ADDR_W-1:0] sampleAddr,
  input  logic [DATA_W-1:0] busRdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busRe,
  output logic              busWe,
  output logic [DATA_W-1:0] busWdata,
  output logic              sampleAck,
  output logic [DATA_W-1:0] sampleData,
  output logic              lastIdx
);

  logic [PAGE_W-1:0] pageQ;
  logic [IDX_W-1:0]  idxQ;
  logic [DATA_W-1:0] spriteQ;
  logic [DATA_W-1:0] sampleQ;
  logic              ackQ;

  assign lastIdx = &idxQ;

  always_comb begin
    busAddr = '0;
    if (strobe.rdSprite)      busAddr = {pageQ, idxQ};
    else if (strobe.rdSample) busAddr = sampleAddr;
    else if (strobe.rdPc)     busAddr = cpuPc;
    else if (strobe.wrPort)   busAddr = PORT_ADDR[ADDR_W-1:0];
  end

  assign busRe    = strobe.rdSprite | strobe.rdSample | strobe.rdPc;
  assign busWe    = strobe.wrPort;
  assign busWdata = strobe.wrPort ? spriteQ : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageQ   <= '0;
      idxQ    <= '0;
      spriteQ <= '0;
      sampleQ <= '0;
      ackQ    <= 1'b0;
    end else begin
      if (strobe.loadPage) begin
        pageQ <= trigData;
        idxQ  <= '0;
      end else if (strobe.incIdx) begin
        idxQ <= idxQ + 1'b1;
      end
      // separate holding registers keep sprite data clear of sample fetches
      if (strobe.rdSprite) spriteQ <= busRdata;
      if (strobe.rdSample) sampleQ <= busRdata;
      ackQ <= strobe.rdSample;
    end
  end

  assign sampleAck  = ackQ;
  assign sampleData = sampleQ;

  // R10: never read and write in one cycle
  a_r10_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(busRe && busWe));

  // R4: each port write carries the byte read in the cycle before
  a_r4_write_carries_read: assert property (@(posedge clk) disable iff (!rstN)
    busWe |-> (busWdata == $past(busRdata)) && $past(busRe));

endmodule

// File: rtl/sprite_dma.sv
module sprite_dma
  import sprite_dma_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter int          IDX_W     = 8,
  parameter logic [15:0] PORT_ADDR = 16'h0F04,
  localparam int         PAGE_W    = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trigWe,
  input  logic [PAGE_W-1:0] trigData,
  input  logic              cpuOddCycle,
  input  logic [ADDR_W-1:0] cpuPc,
  input  logic              sampleReq,
  input  logic [ADDR_W-1:0] sampleAddr,
  output logic              sampleAck,
  output logic [DATA_W-1:0] sampleData,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busRe,
  output logic              busWe,
  output logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] busRdata,
  output logic              cpuHalt
);

  dmaStrobe_t strobe;
  logic       lastIdx;

  sprite_dma_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .trigWe      (trigWe),
    .cpuOddCycle (cpuOddCycle),
    .sampleReq   (sampleReq),
    .sampleAck   (sampleAck),
    .lastIdx     (lastIdx),
    .strobe      (strobe),
    .cpuHalt     (cpuHalt)
  );

  sprite_dma_datapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .IDX_W     (IDX_W),
    .PORT_ADDR (PORT_ADDR)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .trigData   (trigData),
    .cpuPc      (cpuPc),
    .sampleAddr (sampleAddr),
    .busRdata   (busRdata),
    .busAddr    (busAddr),
    .busRe      (busRe),
    .busWe      (busWe),
    .busWdata   (busWdata),
    .sampleAck  (sampleAck),
    .sampleData (sampleData),
    .lastIdx    (lastIdx)
  );

endmodule

// File: tb/sprite_dma_tb.sv
`timescale 1ns/1ps
module sprite_dma_tb;

  localparam logic [15:0] PORT_A   = 16'h0F04;
  localparam logic [15:0] SAMPLE_A = 16'hC0A5;
  localparam logic [15:0] PC_A     = 16'h8ABC;
  localparam logic [15:0] NONE     = 16'hFFFF;

  typedef struct packed {
    logic        odd;
    logic [7:0]  page;
    logic [15:0] slot;    // cycle in which the sample request rises, NONE = never
    logic [15:0] retrig;  // cycle of a stray trigger write, 0 = none
    logic [15:0] expHalt;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h02, NONE,   16'd0,  16'd513},
    '{1'b1, 8'h07, NONE,   16'd0,  16'd514},
    '{1'b0, 8'h3F, 16'd1,  16'd0,  16'd515},
    '{1'b1, 8'h10, 16'd2,  16'd0,  16'd516},
    '{1'b0, 8'h55, 16'd100, 16'd0, 16'd515},
    '{1'b1, 8'hA3, 16'd300, 16'd0, 16'd516},
    '{1'b0, 8'hFE, 16'd511, 16'd0, 16'd515},
    '{1'b0, 8'h21, 16'd0,  16'd0,  16'd515},
    '{1'b1, 8'h66, NONE,   16'd77, 16'd514}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        trigWe = 1'b0;
  logic [7:0]  trigData = 8'h00;
  logic        cpuOddCycle = 1'b0;
  logic [15:0] cpuPc = PC_A;
  logic        sampleReq = 1'b0;
  logic [15:0] sampleAddr = SAMPLE_A;
  logic        sampleAck;
  logic [7:0]  sampleData;
  logic [15:0] busAddr;
  logic        busRe, busWe;
  logic [7:0]  busWdata;
  logic [7:0]  busRdata;
  logic        cpuHalt;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] memf(input logic [15:0] a);
    return a[7:0] ^ {a[14:8], a[15]} ^ 8'h5A;
  endfunction

  assign busRdata = busRe ? memf(busAddr) : 8'h00;

  sprite_dma u_dut (
    .clk(clk), .rstN(rstN), .trigWe(trigWe), .trigData(trigData),
    .cpuOddCycle(cpuOddCycle), .cpuPc(cpuPc), .sampleReq(sampleReq),
    .sampleAddr(sampleAddr), .sampleAck(sampleAck), .sampleData(sampleData),
    .busAddr(busAddr), .busRe(busRe), .busWe(busWe), .busWdata(busWdata),
    .busRdata(busRdata), .cpuHalt(cpuHalt)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic runVec(input vec_t v, input int vi);
    int haltCycles = -1;
    int wcnt = 0, rcnt = 0, dataErr = 0, orderErr = 0, quietErr = 0;
    int sampleReads = 0, pcErr = 0, ackErr = 0, ackSeen = 0;
    int expFetch;
    bit reqOn, prevSample = 0, curSample;
    string rq;
    @(posedge clk); #1;
    trigWe = 1'b1; trigData = v.page; cpuOddCycle = v.odd;
    reqOn = (v.slot == 16'd0);
    sampleReq = reqOn;
    for (int k = 1; k < 2000; k++) begin
      @(posedge clk); #1;
      trigWe = (v.retrig != 16'd0) && (k == int'(v.retrig));
      trigData = trigWe ? 8'hE7 : v.page;
      if (v.slot != NONE && k == int'(v.slot)) reqOn = 1'b1;
      sampleReq = reqOn;
      @(negedge clk);
      if (!cpuHalt) begin haltCycles = k - 1; break; end
      if (k == 1 || (v.odd && k == 2)) if (busRe || busWe) quietErr++;
      if (prevSample) begin
        if (!(busRe && busAddr == PC_A)) pcErr++;
        if (!sampleAck || sampleData != memf(SAMPLE_A)) ackErr++;
        else ackSeen++;
      end else if (sampleAck) ackErr++;
      if (sampleAck) reqOn = 1'b0;
      curSample = 1'b0;
      if (busWe) begin
        if (busAddr != PORT_A || busWdata != memf({v.page, wcnt[7:0]})) dataErr++;
        wcnt++;
      end else if (busRe) begin
        if (busAddr == SAMPLE_A) begin
          sampleReads++;
          curSample = 1'b1;
        end else if (!prevSample) begin
          if (busAddr != {v.page, rcnt[7:0]}) orderErr++;
          rcnt++;
        end
      end
      prevSample = curSample;
    end
    sampleReq = 1'b0;
    expFetch = (v.slot != NONE) ? 1 : 0;
    rq = (v.retrig != 16'd0) ? "R8" : "R3";
    chk(haltCycles == int'(v.expHalt), rq, $sformatf("vec%0d halt cycles", vi),
        haltCycles, int'(v.expHalt));
    chk(wcnt == 256, "R4", $sformatf("vec%0d port writes", vi), wcnt, 256);
    rq = (v.retrig != 16'd0) ? "R8" : "R6";
    chk(dataErr == 0, rq, $sformatf("vec%0d corrupted port writes", vi), dataErr, 0);
    chk(orderErr == 0 && rcnt == 256, "R5", $sformatf("vec%0d sprite read order errors", vi),
        orderErr, 0);
    chk(quietErr == 0, "R10", $sformatf("vec%0d bus use in halt/align", vi), quietErr, 0);
    rq = (v.slot == 16'd0) ? "R9" : "R5";
    chk(sampleReads == expFetch && pcErr == 0, rq,
        $sformatf("vec%0d sample reads (pc errors %0d)", vi, pcErr), sampleReads, expFetch);
    chk(ackSeen == expFetch && ackErr == 0, "R6",
        $sformatf("vec%0d acks (errors %0d)", vi, ackErr), ackSeen, expFetch);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1: idle after reset
    chk(!cpuHalt && !busRe && !busWe && !sampleAck, "R1", "reset outputs",
        {cpuHalt, busRe, busWe, sampleAck}, 0);

    // R7: idle sample fetch
    @(posedge clk); #1 sampleReq = 1'b1;
    @(negedge clk);
    chk(!cpuHalt && !busRe, "R7", "request cycle quiet", {cpuHalt, busRe}, 0);
    @(posedge clk); #1;
    @(negedge clk);
    chk(cpuHalt && busRe && busAddr == SAMPLE_A, "R7", "stolen read address",
        busAddr, SAMPLE_A);
    @(posedge clk); #1;
    @(negedge clk);
    chk(sampleAck && !cpuHalt, "R7", "ack with halt released", {sampleAck, cpuHalt}, 2);
    chk(sampleData == memf(SAMPLE_A), "R7", "idle sample data", sampleData, memf(SAMPLE_A));
    @(posedge clk); #1 sampleReq = 1'b0;
    @(negedge clk);
    chk(!sampleAck && !cpuHalt && !busRe, "R7", "single fetch only",
        {sampleAck, cpuHalt, busRe}, 0);

    // table of transfers: R2 R3 R4 R5 R6 R8 R9 R10
    for (int i = 0; i < NV; i++) runVec(VECS[i], i);

    // R2: halt rises right after trigger, first read at page base
    @(posedge clk); #1 trigWe = 1'b1; trigData = 8'h4C; cpuOddCycle = 1'b0;
    @(negedge clk);
    chk(!cpuHalt, "R2", "halt low in trigger cycle", cpuHalt, 0);
    @(posedge clk); #1 trigWe = 1'b0;
    @(negedge clk);
    chk(cpuHalt, "R2", "halt high after trigger", cpuHalt, 1);
    @(posedge clk); #1;
    @(negedge clk);
    chk(busRe && busAddr == 16'h4C00, "R2", "first read address", busAddr, 16'h4C00);
    while (cpuHalt) @(negedge clk);
    finish_run();
  end

endmodule